// File: doc/BRIEF.md
# Processor power-up reset sequencer

This block is a synchronous state machine that carries a processor core from supply-good to normal instruction fetch. It first checks that the system holds its active-low reset correctly around the rise of supply-good, and counts a minimum hold time. After reset is released it waits out a clock-lock interval. It then waits for the system's clock-forward reset to fall and lines up a self-test start with the next framing-clock tick.

After self-test it reports the result on a test-status pin. A fixed window of sixteen low cycles comes first, then the pin settles at its final level. A passing core runs its serial boot-ROM load with the active-low output enable asserted. A failing core parks in a halt state.

Once the load is done, a second fall of the same clock-forward reset pulses the interface reset, starts the outgoing clocks and releases the internal core reset in a single cycle. Commands are held off for 264 cycles. The block then enters run and issues a one-cycle fetch-start pulse carrying the reset vector 0x780.

The clock generator, the self-test engine, the ROM loader and the clock-forwarding datapath lie outside the block. The bench models them as simple stubs.

Top module: `pup_reset_seq`

## Requirements
- R1: In the power-up state, if supply-good is sampled high while `sys_rst_n` is high, `proto_err` goes to 1 in the next cycle. If it is sampled high while `sys_rst_n` is low, the hold state is entered and `proto_err` stays 0.
- R2: In the hold state, each cycle with `sys_rst_n` low adds one to a hold count. The entry cycle is not counted. When `sys_rst_n` rises, the sequence continues if the count is at least `HOLD_CYC`. Otherwise `proto_err` goes to 1 and stays at 1 until `sys_rst_n` is low again.
- R3: After release, the block waits `RAMP_CYC` cycles for clock lock. It then waits for a falling edge of `cfwd_rst`, meaning high in one sampled cycle and low in the next.
- R4: `bist_start` is a one-cycle pulse in the cycle after the first `frame_tick` sampled after that falling edge. Level changes on `cfwd_rst` from that edge until the boot-ROM load ends do not abort or restart the sequence.
- R5: `test_stat` is 1 from power-up until self-test completes. Starting in the cycle after `bist_done` it is 0 for exactly 16 cycles. It then stays 0 if `bist_pass` was 1 with `bist_done`, and goes to 1 otherwise.
- R6: After a pass, `rom_oe_n` is 0 from the cycle after the 16-cycle window until the cycle after `rom_done`, when it returns to 1.
- R7: After a fail, the block halts with `test_stat` at 1, `rom_oe_n` at 1 and `core_rst` at 1. `cmd_en` and `fetch_start` stay 0 whatever `rom_done` and `cfwd_rst` do, until `sys_rst_n` is low.
- R8: After the load ends, the cycle following the next falling edge of `cfwd_rst` has `if_rst` high for exactly one cycle. In that same cycle `clk_out_en` rises and `core_rst` falls.
- R9: `cmd_en` rises exactly 264 cycles after `core_rst` falls and then stays high. `fetch_start` is high only in that first cycle. `fetch_vec` is 0x780 while `fetch_start` is high and 0 otherwise.
- R10: `sys_rst_n` low in any state past the hold state restarts the sequence. In the next cycle every output is back at its reset value: `core_rst`=1, `rom_oe_n`=1, `test_stat`=1, all other outputs 0. The hold count restarts from zero.
- R11: A synchronous active-high `rst` puts the block in the power-up state with the same output values as R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply-good flag |
| sys_rst_n | input | 1 | System reset, active low |
| cfwd_rst | input | 1 | System-driven clock-forward reset, deasserted edge is used |
| frame_tick | input | 1 | One-cycle framing-clock tick |
| bist_done | input | 1 | Self-test complete |
| bist_pass | input | 1 | Self-test result, valid with `bist_done` |
| rom_done | input | 1 | Boot-ROM load complete |
| bist_start | output | 1 | One-cycle self-test start pulse |
| test_stat | output | 1 | Test-status pin |
| rom_oe_n | output | 1 | Boot-ROM output enable, active low |
| if_rst | output | 1 | One-cycle interface reset pulse |
| clk_out_en | output | 1 | Outgoing clocks running |
| core_rst | output | 1 | Internal core reset |
| cmd_en | output | 1 | Command-issue enable |
| fetch_start | output | 1 | One-cycle fetch-start pulse |
| fetch_vec | output | 16 | Reset vector, valid with `fetch_start` |
| proto_err | output | 1 | Reset protocol error |

## Verification
A wrong state or a miscounted timer shows at the ports in the cycle it happens. A premature or missing transition makes `bist_start`, `rom_oe_n`, `if_rst` or `cmd_en` move one cycle early or late, or not at all. A miscount in the status window or the command hold-off shows as a 16- or 264-cycle window that is off by one, and the bench measures both windows sample by sample. A lost pass/fail result shows right after the window, as the wrong `test_stat` level together with the wrong `rom_oe_n`.

// File: rtl/pup_pkg.sv
package pup_pkg;

    localparam int STAT_LOW_CYC = 16;
    localparam int CMD_WAIT_CYC = 264;
    localparam int VEC_W        = 16;
    localparam logic [VEC_W-1:0] RESET_VEC = 16'h0780;

    typedef enum logic [3:0] {
        ST_PWR,
        ST_HOLD,
        ST_RAMP,
        ST_CF1,
        ST_ARM,
        ST_BSTART,
        ST_BIST,
        ST_STAT,
        ST_ROM,
        ST_CF2,
        ST_CMDW,
        ST_FETCH,
        ST_RUN,
        ST_HALT,
        ST_ERR
    } pup_state_e;

    typedef struct packed {
        logic bist_start;
        logic test_stat;
        logic rom_oe_n;
        logic if_rst;
        logic clk_out_en;
        logic core_rst;
        logic cmd_en;
        logic fetch_start;
        logic proto_err;
    } pup_out_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // States in which the core logic is out of reset
    function automatic logic core_live(input pup_state_e s);
        return (s == ST_CMDW) || (s == ST_FETCH) || (s == ST_RUN);
    endfunction

    // States in which the status pin reads low (window plus passed path)
    function automatic logic stat_low(input pup_state_e s);
        return (s == ST_STAT) || (s == ST_ROM) || (s == ST_CF2) || core_live(s);
    endfunction

    // States in which a system reset does not restart the sequence
    function automatic logic pre_release(input pup_state_e s);
        return (s == ST_PWR) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/pup_fall_det.sv
module pup_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic din_q;

    always_ff @(posedge clk) begin
        if (rst) din_q <= 1'b0;
        else     din_q <= din;
    end

    assign fall = din_q & ~din;
endmodule

// File: rtl/pup_timer.sv
module pup_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)         cnt <= '0;
        else if (cnt != '1)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pup_fsm.sv
module pup_fsm
    import pup_pkg::*;
#(
    parameter int HOLD_CYC = 1000,
    parameter int RAMP_CYC = 100,
    parameter int CNT_W    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_good,
    input  logic             sys_rst_n,
    input  logic             cf_fall,
    input  logic             frame_tick,
    input  logic             bist_done,
    input  logic             bist_pass,
    input  logic             rom_done,
    input  logic [CNT_W-1:0] cnt,
    output logic             timer_clr,
    output pup_state_e       st
);
    localparam logic [CNT_W-1:0] HOLD_LIM  = CNT_W'(HOLD_CYC);
    localparam logic [CNT_W-1:0] RAMP_LAST = CNT_W'(RAMP_CYC - 1);
    localparam logic [CNT_W-1:0] STAT_LAST = CNT_W'(STAT_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] CMDW_LAST = CNT_W'(CMD_WAIT_CYC - 1);

    pup_state_e st_q, nxt;
    logic       pass_q;

    always_comb begin
        nxt = st_q;
        unique case (st_q)
            ST_PWR:    if (pwr_good) nxt = sys_rst_n ? ST_ERR : ST_HOLD;
            ST_HOLD:   if (sys_rst_n) nxt = (cnt >= HOLD_LIM) ? ST_RAMP : ST_ERR;
            ST_RAMP:   if (cnt == RAMP_LAST) nxt = ST_CF1;
            ST_CF1:    if (cf_fall) nxt = ST_ARM;
            ST_ARM:    if (frame_tick) nxt = ST_BSTART;
            ST_BSTART: nxt = ST_BIST;
            ST_BIST:   if (bist_done) nxt = ST_STAT;
            ST_STAT:   if (cnt == STAT_LAST) nxt = pass_q ? ST_ROM : ST_HALT;
            ST_ROM:    if (rom_done) nxt = ST_CF2;
            ST_CF2:    if (cf_fall) nxt = ST_CMDW;
            ST_CMDW:   if (cnt == CMDW_LAST) nxt = ST_FETCH;
            ST_FETCH:  nxt = ST_RUN;
            ST_RUN,
            ST_HALT,
            ST_ERR:    nxt = st_q;
            default:   nxt = ST_PWR;
        endcase
        if (!sys_rst_n && !pre_release(st_q))
            nxt = ST_PWR;
    end

    assign timer_clr = (nxt != st_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_PWR;
            pass_q <= 1'b0;
        end else begin
            st_q <= nxt;
            if (nxt == ST_PWR)
                pass_q <= 1'b0;
            else if (st_q == ST_BIST && bist_done)
                pass_q <= bist_pass;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/pup_outdec.sv
module pup_outdec
    import pup_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  pup_state_e       st,
    input  logic [CNT_W-1:0] cnt,
    output pup_out_t         outs,
    output logic [VEC_W-1:0] vec
);
    always_comb begin
        outs.bist_start  = (st == ST_BSTART);
        outs.test_stat   = ~stat_low(st);
        outs.rom_oe_n    = (st != ST_ROM);
        outs.if_rst      = (st == ST_CMDW) && (cnt == '0);
        outs.clk_out_en  = core_live(st);
        outs.core_rst    = ~core_live(st);
        outs.cmd_en      = (st == ST_FETCH) || (st == ST_RUN);
        outs.fetch_start = (st == ST_FETCH);
        outs.proto_err   = (st == ST_ERR);
        vec              = (st == ST_FETCH) ? RESET_VEC : '0;
    end
endmodule

// File: rtl/pup_reset_seq.sv
module pup_reset_seq
    import pup_pkg::*;
#(
    parameter int HOLD_CYC = 10_000_000,
    parameter int RAMP_CYC = 2_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_good,
    input  logic             sys_rst_n,
    input  logic             cfwd_rst,
    input  logic             frame_tick,
    input  logic             bist_done,
    input  logic             bist_pass,
    input  logic             rom_done,
    output logic             bist_start,
    output logic             test_stat,
    output logic             rom_oe_n,
    output logic             if_rst,
    output logic             clk_out_en,
    output logic             core_rst,
    output logic             cmd_en,
    output logic             fetch_start,
    output logic [VEC_W-1:0] fetch_vec,
    output logic             proto_err
);
    localparam int CNT_MAX = max3(HOLD_CYC, RAMP_CYC, CMD_WAIT_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             cf_fall;
    logic             timer_clr;
    logic [CNT_W-1:0] cnt;
    pup_state_e       st;
    pup_out_t         outs;

    pup_fall_det u_fall (
        .clk  (clk),
        .rst  (rst),
        .din  (cfwd_rst),
        .fall (cf_fall)
    );

    pup_timer #(.CNT_W(CNT_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (timer_clr),
        .cnt (cnt)
    );

    pup_fsm #(
        .HOLD_CYC (HOLD_CYC),
        .RAMP_CYC (RAMP_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pwr_good   (pwr_good),
        .sys_rst_n  (sys_rst_n),
        .cf_fall    (cf_fall),
        .frame_tick (frame_tick),
        .bist_done  (bist_done),
        .bist_pass  (bist_pass),
        .rom_done   (rom_done),
        .cnt        (cnt),
        .timer_clr  (timer_clr),
        .st         (st)
    );

    pup_outdec #(.CNT_W(CNT_W)) u_dec (
        .st   (st),
        .cnt  (cnt),
        .outs (outs),
        .vec  (fetch_vec)
    );

    assign bist_start  = outs.bist_start;
    assign test_stat   = outs.test_stat;
    assign rom_oe_n    = outs.rom_oe_n;
    assign if_rst      = outs.if_rst;
    assign clk_out_en  = outs.clk_out_en;
    assign core_rst    = outs.core_rst;
    assign cmd_en      = outs.cmd_en;
    assign fetch_start = outs.fetch_start;
    assign proto_err   = outs.proto_err;
endmodule

// File: rtl/pup_reset_seq_chk.sv
module pup_reset_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        sys_rst_n,
    input logic        bist_start,
    input logic        test_stat,
    input logic        rom_oe_n,
    input logic        if_rst,
    input logic        clk_out_en,
    input logic        core_rst,
    input logic        cmd_en,
    input logic        fetch_start,
    input logic [15:0] fetch_vec,
    input logic        proto_err
);
    // R4
    bist_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bist_start |=> !bist_start);

    // R6
    rom_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !rom_oe_n |-> !test_stat);

    // R7
    cmd_after_pass_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_en |-> !test_stat);

    // R8
    ifrst_group_chk: assert property (@(posedge clk) disable iff (rst)
        if_rst |-> (clk_out_en && !core_rst && !cmd_en));

    // R8
    core_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> if_rst);

    // R9
    fetch_vec_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_start |-> (cmd_en && fetch_vec == 16'h0780));

    // R9
    cmd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_en && sys_rst_n) |=> cmd_en);

    // R10
    sysrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !sys_rst_n |=> (core_rst && rom_oe_n && !cmd_en && !clk_out_en && !fetch_start));

    // R2
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> (core_rst && rom_oe_n && !bist_start));
endmodule

bind pup_reset_seq pup_reset_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sys_rst_n   (sys_rst_n),
    .bist_start  (bist_start),
    .test_stat   (test_stat),
    .rom_oe_n    (rom_oe_n),
    .if_rst      (if_rst),
    .clk_out_en  (clk_out_en),
    .core_rst    (core_rst),
    .cmd_en      (cmd_en),
    .fetch_start (fetch_start),
    .fetch_vec   (fetch_vec),
    .proto_err   (proto_err)
);

// File: tb/pup_reset_seq_bench.sv
module pup_reset_seq_bench;
    localparam int HOLD = 20;
    localparam int RAMP = 8;

    logic clk = 1'b0;
    logic rst, pwr_good, sys_rst_n, cfwd_rst, frame_tick, bist_done, bist_pass, rom_done;
    logic bist_start, test_stat, rom_oe_n, if_rst, clk_out_en, core_rst, cmd_en, fetch_start, proto_err;
    logic [15:0] fetch_vec;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pup_reset_seq #(.HOLD_CYC(HOLD), .RAMP_CYC(RAMP)) u_pup_reset_seq (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .sys_rst_n(sys_rst_n),
        .cfwd_rst(cfwd_rst), .frame_tick(frame_tick), .bist_done(bist_done),
        .bist_pass(bist_pass), .rom_done(rom_done), .bist_start(bist_start),
        .test_stat(test_stat), .rom_oe_n(rom_oe_n), .if_rst(if_rst),
        .clk_out_en(clk_out_en), .core_rst(core_rst), .cmd_en(cmd_en),
        .fetch_start(fetch_start), .fetch_vec(fetch_vec), .proto_err(proto_err)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] idle_vec();
        // core_rst clk_out_en cmd_en rom_oe_n test_stat proto_err bist_start if_rst fetch_start
        return 9'b100110000;
    endfunction

    function automatic logic [8:0] out_vec();
        return {core_rst, clk_out_en, cmd_en, rom_oe_n, test_stat, proto_err, bist_start, if_rst, fetch_start};
    endfunction

    function automatic bit hold_ok(input int n);
        return n >= HOLD;
    endfunction

    task automatic chk_idle(input string req);
        chk(out_vec() == idle_vec() && fetch_vec == 16'h0, req, {23'd0, out_vec()}, {23'd0, idle_vec()});
    endtask

    task automatic restart(input string req);
        sys_rst_n = 1'b0;
        cfwd_rst  = 1'b1;
        tick();
        chk_idle(req);
    endtask

    // Precondition: power-up state with sys_rst_n low
    task automatic boot(input int n_hold, input bit pass, input bit abort_rom);
        int  d;
        bit  bad;
        pwr_good = 1'b1;
        tick();
        chk(proto_err == 1'b0, "R1 hold entry", proto_err, 0);
        repeat (n_hold) tick();
        sys_rst_n = 1'b1;
        tick();
        chk(proto_err == !hold_ok(n_hold), "R2 hold length", proto_err, !hold_ok(n_hold));
        if (!hold_ok(n_hold)) begin
            repeat (5) tick();
            chk(proto_err == 1'b1 && core_rst == 1'b1, "R2 error sticky", proto_err, 1);
            restart("R2 error cleared by reset");
            return;
        end
        repeat (RAMP + 1 + int'($urandom % 4)) tick();
        chk(bist_start == 1'b0, "R3 no start before edge", bist_start, 0);
        cfwd_rst = 1'b0;
        tick();
        cfwd_rst = 1'b1;   // reassertion inside window, R4 ignore
        bad = 0;
        d = int'($urandom % 5);
        repeat (d) begin
            tick();
            if (bist_start) bad = 1;
        end
        chk(!bad, "R4 no start before frame tick", bad, 0);
        frame_tick = 1'b1;
        tick();
        frame_tick = 1'b0;
        chk(bist_start == 1'b1, "R4 start pulse", bist_start, 1);
        tick();
        chk(bist_start == 1'b0, "R4 pulse one cycle", bist_start, 0);
        repeat (int'($urandom % 6)) tick();
        chk(test_stat == 1'b1, "R5 status high before done", test_stat, 1);
        bist_pass = pass;
        bist_done = 1'b1;
        tick();
        bist_done = 1'b0;
        bist_pass = 1'b0;
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            if (i > 0) tick();
            if (test_stat !== 1'b0) bad = 1;
        end
        chk(!bad, "R5 16-cycle low window", bad, 0);
        tick();
        chk(test_stat == !pass, "R5 final status", test_stat, !pass);
        chk(rom_oe_n == !pass, "R6 rom enable on pass", rom_oe_n, !pass);
        if (!pass) begin
            bad = 0;
            for (int i = 0; i < 30; i++) begin
                rom_done = (i % 5 == 2);
                cfwd_rst = (i % 3 != 0);
                tick();
                if (cmd_en || fetch_start || !test_stat || !rom_oe_n || !core_rst) bad = 1;
            end
            rom_done = 1'b0;
            chk(!bad, "R7 halt holds", bad, 0);
            restart("R7 halt left by reset");
            return;
        end
        bad = 0;
        d = 3 + int'($urandom % 6);
        for (int i = 0; i < d; i++) begin
            cfwd_rst = $urandom % 2 == 1;
            tick();
            if (rom_oe_n !== 1'b0) bad = 1;
        end
        cfwd_rst = 1'b1;
        tick();
        chk(!bad && rom_oe_n == 1'b0, "R4 cfwd ignored during load", bad, 0);
        if (abort_rom) begin
            restart("R10 abort during load");
            return;
        end
        rom_done = 1'b1;
        tick();
        rom_done = 1'b0;
        chk(rom_oe_n == 1'b1 && core_rst == 1'b1, "R6 enable off after load", rom_oe_n, 1);
        repeat (int'($urandom % 5)) tick();
        chk(if_rst == 1'b0 && core_rst == 1'b1, "R8 waiting for second edge", if_rst, 0);
        cfwd_rst = 1'b0;
        tick();
        chk(if_rst && clk_out_en && !core_rst && !cmd_en, "R8 release group",
            {if_rst, clk_out_en, core_rst, cmd_en}, 4'b1100);
        tick();
        chk(if_rst == 1'b0, "R8 if_rst one cycle", if_rst, 0);
        bad = 0;
        if (cmd_en) bad = 1;
        for (int i = 2; i < 264; i++) begin
            tick();
            if (cmd_en || fetch_start) bad = 1;
        end
        chk(!bad, "R9 command hold-off", bad, 0);
        tick();
        chk(cmd_en && fetch_start && fetch_vec == 16'h0780, "R9 fetch at 264", fetch_vec, 16'h0780);
        tick();
        chk(cmd_en && !fetch_start && fetch_vec == 16'h0, "R9 fetch one cycle",
            {fetch_start, fetch_vec}, 17'h0);
        repeat (int'($urandom % 8)) tick();
        chk(cmd_en == 1'b1, "R9 cmd_en stays", cmd_en, 1);
        restart("R10 reset from run");
    endtask

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1; pwr_good = 1'b0; sys_rst_n = 1'b0; cfwd_rst = 1'b1;
        frame_tick = 1'b0; bist_done = 1'b0; bist_pass = 1'b0; rom_done = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        chk_idle("R11 reset state");
        repeat (4) tick();
        chk_idle("R11 idle without supply");

        // R1 error: supply good while system reset released
        sys_rst_n = 1'b1;
        pwr_good  = 1'b1;
        tick();
        chk(proto_err == 1'b1, "R1 reset missing at supply-good", proto_err, 1);
        restart("R10 error cleared");

        boot(HOLD - 1, 1'b1, 1'b0);
        boot(HOLD, 1'b1, 1'b0);
        boot(HOLD + 5, 1'b0, 1'b0);
        boot(HOLD + 2, 1'b1, 1'b1);
        boot(HOLD - 3, 1'b1, 1'b0);
        for (int k = 0; k < 5; k++)
            boot(HOLD - 2 + int'($urandom % 8), ($urandom % 4) != 0, ($urandom % 4) == 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule